// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a ring of transmit descriptors held in system memory, one frame per descriptor. For each descriptor it reads four 32-bit words over a simple word-wide memory port: control flags, buffer address, status-and-length, and the pointer to the next descriptor. If the descriptor is owned by the hardware, the block hands the buffer address and the frame length to an external frame sender through a start/done handshake. It then writes the descriptor back with ownership returned and its status updated, and moves on to the next descriptor.

Software enables transmission with a level input. On the rising edge of that input, the current-descriptor pointer is loaded from the list base. No traffic starts until a demand strobe arrives. After that, the walker keeps running until it finds a descriptor that software still owns, hits a descriptor read error, or transmission is disabled. The walker reports three kinds of one-cycle event pulses to a separate interrupt block: frame complete, descriptor unavailable, and bus error. When transmission is switched off, a sticky halted flag is set.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset, `busy`, `mem_req`, `snd_start`, all three event pulses and `tx_halted` are 0, and `cur_desc` and `cur_buf` are 0.
- R2: When `tx_en` rises, `cur_desc` is loaded with `list_base` with its two low bits cleared. No memory request is made until a demand strobe arrives.
- R3: A `tx_demand` pulse while `tx_en` is high starts the walker. It reads the words at `cur_desc`+0 (flags), +4 (buffer address), +8 (status/length) and +12 (next pointer), and keeps processing successive descriptors without further demand. A demand while `tx_en` is low has no effect.
- R4: If bit 31 (owner) of the flags word is 0, the walker stops with one `ev_unavail` pulse. It starts no send, makes no write, and leaves `cur_desc` on that descriptor.
- R5: An error response to any descriptor read stops the walker with one `ev_buserr` pulse. It starts no send and makes no write-back.
- R6: `snd_start` is a one-cycle pulse. `snd_addr` is the buffer word, `cur_buf` takes that value, and `snd_len` is bits 15:0 of the status word. If flags bit 1 (pad) is set and the length is below `MIN_LEN` (60), `snd_len` is `MIN_LEN`.
- R7: After the send, the flags word is written back to +0 with bit 31 cleared. Then the status word is written to +8 with bits 31:16 cleared, the original length kept, and bit 16 (complete) set on a clean send. `cur_desc` then takes the next pointer with its two low bits cleared.
- R8: `ev_complete` pulses after a clean send only when flags bit 2 (interrupt enable) is set.
- R9: When the sender reports an error (`snd_err` with `snd_done`), `ev_buserr` pulses and no `ev_complete` is raised. The descriptor is still written back with the owner bit cleared and the complete bit 0, and the walker continues with the next descriptor.
- R10: A falling `tx_en` stops the walker at the next clock edge, dropping `busy` and `mem_req` without writing back. It also sets `tx_halted`, which stays set until a `halt_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable level |
| tx_demand | input | 1 | Transmit demand strobe |
| list_base | input | AW | Descriptor list start address |
| halt_clr | input | 1 | Clears the halted flag |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write request |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Response for the pending request |
| mem_err | input | 1 | Error flag qualifying `mem_ack` |
| mem_rdata | input | 32 | Read data qualifying `mem_ack` |
| snd_start | output | 1 | Start pulse to the frame sender |
| snd_addr | output | AW | Frame buffer address |
| snd_len | output | 16 | Frame length in bytes, after padding |
| snd_done | input | 1 | Sender finished |
| snd_err | input | 1 | Sender hit a buffer read error, with `snd_done` |
| cur_desc | output | AW | Current descriptor address |
| cur_buf | output | AW | Current buffer address |
| busy | output | 1 | Walker active |
| tx_halted | output | 1 | Sticky transmit-halted flag |
| ev_complete | output | 1 | Frame complete event pulse |
| ev_unavail | output | 1 | Descriptor unavailable event pulse |
| ev_buserr | output | 1 | Bus error event pulse |

## Verification
The assertions assume that the memory answers each request with exactly one `mem_ack`, and only while the request is held. They also assume that the sender raises `snd_done` only after a `snd_start`, and that `list_base` is steady around the enable edge. The bench memory answers one cycle after it sees a request, then drops its acknowledge for a cycle, so it never acknowledges twice. The sender model answers three cycles after a start and flags an error from the buffer address alone. Stimulus changes only on falling edges, with `tx_en` dropped only while a send is pending.

// File: rtl/txr_pkg.sv
package txr_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LEN_W    = 16;
  // flag and status bit positions inside the descriptor words
  localparam int unsigned OWN_BIT  = 31;
  localparam int unsigned PAD_BIT  = 1;
  localparam int unsigned IEN_BIT  = 2;
  localparam int unsigned DONE_BIT = 16;
  // byte offsets of the four words inside one descriptor
  localparam logic [3:0] OFS_FLAGS = 4'd0;
  localparam logic [3:0] OFS_BUF   = 4'd4;
  localparam logic [3:0] OFS_STAT  = 4'd8;
  localparam logic [3:0] OFS_NEXT  = 4'd12;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_FLAGS,
    ST_RD_BUF,
    ST_RD_STAT,
    ST_RD_NEXT,
    ST_SEND_GO,
    ST_SEND_WAIT,
    ST_WR_FLAGS,
    ST_WR_STAT
  } txr_state_e;
endpackage

// File: rtl/txr_pad.sv
module txr_pad #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MIN_LEN = 60
) (
  input  logic [LEN_W-1:0] raw_len,
  input  logic             pad_en,
  output logic [LEN_W-1:0] out_len
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  logic short_frame;

  always_comb begin
    short_frame = raw_len < MIN_L;
    out_len     = (pad_en && short_frame) ? MIN_L : raw_len;
  end
endmodule

// File: rtl/txr_ptr.sv
module txr_ptr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic [AW-1:0] list_base,
  input  logic          halt_clr,
  input  logic          adv,
  input  logic [AW-1:0] adv_ptr,
  input  logic          buf_ld,
  input  logic [AW-1:0] buf_val,
  output logic [AW-1:0] cur_desc,
  output logic [AW-1:0] cur_buf,
  output logic          tx_halted
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [AW-1:0] ALIGN = ~AW'(3);

  logic          en_q;
  logic          en_rise, en_fall;
  logic [AW-1:0] desc_q, desc_d;
  logic [AW-1:0] bufa_q, bufa_d;
  logic          halt_q, halt_d;

  always_comb begin
    en_rise = tx_en & ~en_q;
    en_fall = en_q & ~tx_en;

    desc_d = desc_q;
    if (en_rise) begin
      desc_d = list_base & ALIGN;
    end else if (adv) begin
      desc_d = adv_ptr;
    end

    bufa_d = bufa_q;
    if (buf_ld) begin
      bufa_d = buf_val;
    end

    halt_d = halt_q;
    if (en_fall) begin
      halt_d = 1'b1;
    end else if (halt_clr) begin
      halt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      desc_q <= '0;
      bufa_q <= '0;
      halt_q <= 1'b0;
    end else begin
      en_q   <= tx_en;
      desc_q <= desc_d;
      bufa_q <= bufa_d;
      halt_q <= halt_d;
    end
  end

  assign cur_desc  = desc_q;
  assign cur_buf   = bufa_q;
  assign tx_halted = halt_q;
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned MIN_LEN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_demand,
  input  logic [AW-1:0]     cur_desc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              snd_start,
  output logic [AW-1:0]     snd_addr,
  output logic [LEN_W-1:0]  snd_len,
  input  logic              snd_done,
  input  logic              snd_err,
  output logic              adv,
  output logic [AW-1:0]     adv_ptr,
  output logic              buf_ld,
  output logic [AW-1:0]     buf_val,
  output logic              busy,
  output logic              ev_complete,
  output logic              ev_unavail,
  output logic              ev_buserr
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [AW-1:0]     ALIGN    = ~AW'(3);
  localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;
  localparam logic [WORD_W-1:0] LEN_MASK = WORD_W'({LEN_W{1'b1}});

  txr_state_e        state_q, state_d;
  logic [WORD_W-1:0] flags_q, flags_d;
  logic [WORD_W-1:0] stat_q,  stat_d;
  logic [AW-1:0]     bufa_q,  bufa_d;
  logic [AW-1:0]     next_q,  next_d;
  logic              evc_q, evc_d;
  logic              evu_q, evu_d;
  logic              evb_q, evb_d;
  logic [3:0]        ofs;
  logic              rd_ok, rd_bad;

  txr_pad #(
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN)
  ) i_pad (
    .raw_len (stat_q[LEN_W-1:0]),
    .pad_en  (flags_q[PAD_BIT]),
    .out_len (snd_len)
  );

  // memory request decode
  always_comb begin
    mem_req = 1'b0;
    mem_we  = 1'b0;
    ofs     = OFS_FLAGS;
    mem_wdata = '0;
    unique case (state_q)
      ST_RD_FLAGS: begin mem_req = 1'b1; ofs = OFS_FLAGS; end
      ST_RD_BUF:   begin mem_req = 1'b1; ofs = OFS_BUF;   end
      ST_RD_STAT:  begin mem_req = 1'b1; ofs = OFS_STAT;  end
      ST_RD_NEXT:  begin mem_req = 1'b1; ofs = OFS_NEXT;  end
      ST_WR_FLAGS: begin
        mem_req = 1'b1; mem_we = 1'b1; ofs = OFS_FLAGS;
        mem_wdata = flags_q & ~OWN_MASK;
      end
      ST_WR_STAT: begin
        mem_req = 1'b1; mem_we = 1'b1; ofs = OFS_STAT;
        mem_wdata = stat_q;
      end
      default: ;
    endcase
    mem_addr = cur_desc + AW'(ofs);
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    flags_d = flags_q;
    stat_d  = stat_q;
    bufa_d  = bufa_q;
    next_d  = next_q;
    evc_d   = 1'b0;
    evu_d   = 1'b0;
    evb_d   = 1'b0;
    adv     = 1'b0;
    buf_ld  = 1'b0;
    rd_ok   = mem_ack & ~mem_err;
    rd_bad  = mem_ack &  mem_err;

    unique case (state_q)
      ST_IDLE: begin
        if (tx_demand) state_d = ST_RD_FLAGS;
      end
      ST_RD_FLAGS: begin
        if (rd_bad) begin
          evb_d = 1'b1; state_d = ST_IDLE;
        end else if (rd_ok) begin
          if (!mem_rdata[OWN_BIT]) begin
            evu_d = 1'b1; state_d = ST_IDLE;
          end else begin
            flags_d = mem_rdata; state_d = ST_RD_BUF;
          end
        end
      end
      ST_RD_BUF: begin
        if (rd_bad) begin
          evb_d = 1'b1; state_d = ST_IDLE;
        end else if (rd_ok) begin
          bufa_d  = mem_rdata[AW-1:0];
          buf_ld  = 1'b1;
          state_d = ST_RD_STAT;
        end
      end
      ST_RD_STAT: begin
        if (rd_bad) begin
          evb_d = 1'b1; state_d = ST_IDLE;
        end else if (rd_ok) begin
          stat_d  = mem_rdata & LEN_MASK;
          state_d = ST_RD_NEXT;
        end
      end
      ST_RD_NEXT: begin
        if (rd_bad) begin
          evb_d = 1'b1; state_d = ST_IDLE;
        end else if (rd_ok) begin
          next_d  = mem_rdata[AW-1:0] & ALIGN;
          state_d = ST_SEND_GO;
        end
      end
      ST_SEND_GO: begin
        state_d = ST_SEND_WAIT;
      end
      ST_SEND_WAIT: begin
        if (snd_done) begin
          if (snd_err) begin
            evb_d = 1'b1;
          end else begin
            stat_d[DONE_BIT] = 1'b1;
            evc_d = flags_q[IEN_BIT];
          end
          state_d = ST_WR_FLAGS;
        end
      end
      ST_WR_FLAGS: begin
        if (mem_ack) begin
          evb_d   = mem_err;
          state_d = ST_WR_STAT;
        end
      end
      ST_WR_STAT: begin
        if (mem_ack) begin
          evb_d   = mem_err;
          adv     = 1'b1;
          state_d = ST_RD_FLAGS;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (!tx_en) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flags_q <= '0;
      stat_q  <= '0;
      bufa_q  <= '0;
      next_q  <= '0;
      evc_q   <= 1'b0;
      evu_q   <= 1'b0;
      evb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      flags_q <= flags_d;
      stat_q  <= stat_d;
      bufa_q  <= bufa_d;
      next_q  <= next_d;
      evc_q   <= evc_d;
      evu_q   <= evu_d;
      evb_q   <= evb_d;
    end
  end

  assign snd_start   = (state_q == ST_SEND_GO);
  assign snd_addr    = bufa_q;
  assign adv_ptr     = next_q;
  assign buf_val     = bufa_d;
  assign busy        = (state_q != ST_IDLE);
  assign ev_complete = evc_q;
  assign ev_unavail  = evu_q;
  assign ev_buserr   = evb_q;
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int unsigned AW      = 32,
  parameter int unsigned MIN_LEN = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          tx_demand,
  input  logic [AW-1:0] list_base,
  input  logic          halt_clr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          snd_start,
  output logic [AW-1:0] snd_addr,
  output logic [15:0]   snd_len,
  input  logic          snd_done,
  input  logic          snd_err,
  output logic [AW-1:0] cur_desc,
  output logic [AW-1:0] cur_buf,
  output logic          busy,
  output logic          tx_halted,
  output logic          ev_complete,
  output logic          ev_unavail,
  output logic          ev_buserr
);
  timeunit 1ns;
  timeprecision 1ps;

  logic          adv, buf_ld;
  logic [AW-1:0] adv_ptr, buf_val;

  txr_ptr #(.AW(AW)) i_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .list_base (list_base),
    .halt_clr  (halt_clr),
    .adv       (adv),
    .adv_ptr   (adv_ptr),
    .buf_ld    (buf_ld),
    .buf_val   (buf_val),
    .cur_desc  (cur_desc),
    .cur_buf   (cur_buf),
    .tx_halted (tx_halted)
  );

  txr_seq #(.AW(AW), .MIN_LEN(MIN_LEN)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .tx_demand   (tx_demand),
    .cur_desc    (cur_desc),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .mem_rdata   (mem_rdata),
    .snd_start   (snd_start),
    .snd_addr    (snd_addr),
    .snd_len     (snd_len),
    .snd_done    (snd_done),
    .snd_err     (snd_err),
    .adv         (adv),
    .adv_ptr     (adv_ptr),
    .buf_ld      (buf_ld),
    .buf_val     (buf_val),
    .busy        (busy),
    .ev_complete (ev_complete),
    .ev_unavail  (ev_unavail),
    .ev_buserr   (ev_buserr)
  );
endmodule

// File: rtl/tx_ring_walker_chk.sv
module tx_ring_walker_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          snd_start,
  input logic          busy,
  input logic          tx_halted,
  input logic          ev_complete,
  input logic          ev_unavail,
  input logic          ev_buserr
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] OWN_MASK = 32'h8000_0000;

  assert_idle_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && tx_en) |=> (mem_req && $stable(mem_addr)));

  assert_unavail_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unavail |-> (!busy && !snd_start));

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snd_start |=> !snd_start);

  assert_wb_owner_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_wdata & OWN_MASK) == 32'h0));

  assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_complete, ev_unavail, ev_buserr}));

  assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !busy);

  assert_fall_sets_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |=> tx_halted);
endmodule

bind tx_ring_walker tx_ring_walker_chk #(.AW(AW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack),
  .snd_start   (snd_start),
  .busy        (busy),
  .tx_halted   (tx_halted),
  .ev_complete (ev_complete),
  .ev_unavail  (ev_unavail),
  .ev_buserr   (ev_buserr)
);

// File: tb/test_tx_ring_walker.sv
module test_tx_ring_walker;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 32;
  localparam int K_SEND = 0, K_DONE = 1, K_UNAV = 2, K_BERR = 3;

  typedef struct {
    int          kind;
    logic [31:0] addr;
    int          len;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_en, tx_demand, halt_clr;
  logic [AW-1:0] list_base;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic snd_start, snd_done, snd_err;
  logic [AW-1:0] snd_addr, cur_desc, cur_buf;
  logic [15:0] snd_len;
  logic busy, tx_halted, ev_complete, ev_unavail, ev_buserr;

  int   n_chk = 0;
  int   n_err = 0;
  exp_t sb[$];
  logic [31:0] mem [256];
  int   snd_cnt;
  logic snd_bad;

  always #2.5 clk = ~clk;

  tx_ring_walker #(.AW(AW), .MIN_LEN(60)) i_tx_ring_walker (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_demand(tx_demand),
    .list_base(list_base), .halt_clr(halt_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .snd_start(snd_start), .snd_addr(snd_addr),
    .snd_len(snd_len), .snd_done(snd_done), .snd_err(snd_err),
    .cur_desc(cur_desc), .cur_buf(cur_buf), .busy(busy),
    .tx_halted(tx_halted), .ev_complete(ev_complete),
    .ev_unavail(ev_unavail), .ev_buserr(ev_buserr)
  );

  function automatic logic bad_addr(input logic [31:0] a);
    return a >= 32'h380;
  endfunction

  // memory model: one acknowledge per held request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_err <= bad_addr(mem_addr);
      if (!bad_addr(mem_addr)) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[9:2]];
      end
    end else begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end
  end

  // sender model: done three cycles after start, error from buffer address
  always @(posedge clk) begin
    if (!rst_n) begin
      snd_cnt <= 0; snd_done <= 1'b0; snd_err <= 1'b0; snd_bad <= 1'b0;
    end else begin
      snd_done <= 1'b0; snd_err <= 1'b0;
      if (snd_start) begin
        snd_cnt <= 3; snd_bad <= bad_addr(snd_addr);
      end else if (snd_cnt == 1) begin
        snd_cnt <= 0; snd_done <= 1'b1; snd_err <= snd_bad;
      end else if (snd_cnt != 0) begin
        snd_cnt <= snd_cnt - 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [31:0] a, input int l);
    exp_t e;
    e.kind = kind; e.addr = a; e.len = l;
    sb.push_back(e);
  endtask

  task automatic pop_cmp(input int kind, input logic [31:0] a, input int l);
    exp_t e;
    if (sb.size() == 0) begin
      chk(1'b0, "R3 unexpected event", 32'(kind), 32'hFFFF_FFFF);
    end else begin
      e = sb.pop_front();
      chk(e.kind == kind, "R3 event order", 32'(kind), 32'(e.kind));
      if (kind == K_SEND) begin
        chk(e.addr == a, "R6 snd_addr", a, e.addr);
        chk(e.len == l, "R6 snd_len", 32'(l), 32'(e.len));
      end
    end
  endtask

  // monitor: scoreboard comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (snd_start)   pop_cmp(K_SEND, snd_addr, int'(snd_len));
      if (ev_complete) pop_cmp(K_DONE, '0, 0);
      if (ev_unavail)  pop_cmp(K_UNAV, '0, 0);
      if (ev_buserr)   pop_cmp(K_BERR, '0, 0);
    end
  end

  task automatic put_desc(input logic [31:0] a, input logic [31:0] fl,
                          input logic [31:0] bf, input logic [31:0] st,
                          input logic [31:0] nx);
    mem[a[9:2]]     = fl;
    mem[a[9:2] + 1] = bf;
    mem[a[9:2] + 2] = st;
    mem[a[9:2] + 3] = nx;
  endtask

  task automatic demand();
    tx_demand = 1'b1;
    @(negedge clk);
    tx_demand = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic sb_empty(input string req);
    chk(sb.size() == 0, req, 32'(sb.size()), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0; tx_en = 1'b0; tx_demand = 1'b0; halt_clr = 1'b0;
    list_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!busy && !mem_req && !snd_start, "R1 idle outputs",
        {29'b0, busy, mem_req, snd_start}, 32'h0);
    chk(!ev_complete && !ev_unavail && !ev_buserr && !tx_halted, "R1 events",
        {28'b0, ev_complete, ev_unavail, ev_buserr, tx_halted}, 32'h0);
    chk(cur_desc == 0 && cur_buf == 0, "R1 pointers", cur_desc | cur_buf, 32'h0);

    // R3: demand with transmit disabled has no effect
    list_base = 32'h102;
    demand();
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req, "R3 demand ignored while disabled",
        {30'b0, busy, mem_req}, 32'h0);
    chk(cur_desc == 0, "R3 pointer untouched", cur_desc, 32'h0);

    // R2: enable edge loads aligned list base, no request yet
    tx_en = 1'b1;
    @(negedge clk);
    chk(cur_desc == 32'h100, "R2 pointer load", cur_desc, 32'h100);
    repeat (6) @(negedge clk);
    chk(!mem_req && !busy, "R2 no request before demand",
        {30'b0, busy, mem_req}, 32'h0);

    // R3 R6 R7 R8: three-frame ring ending at a software-owned descriptor
    put_desc(32'h100, 32'h8000_0004, 32'h200, 32'hFFFF_0064, 32'h140);
    put_desc(32'h140, 32'h8000_0002, 32'h240, 32'h0000_003B, 32'h181);
    put_desc(32'h180, 32'h8000_0006, 32'h280, 32'h0000_003C, 32'h1C0);
    put_desc(32'h1C0, 32'h0000_0000, 32'h2C0, 32'h0000_0010, 32'h100);
    push(K_SEND, 32'h200, 100); push(K_DONE, '0, 0);
    push(K_SEND, 32'h240, 60);
    push(K_SEND, 32'h280, 60);  push(K_DONE, '0, 0);
    push(K_UNAV, '0, 0);
    demand();
    wait_idle();
    sb_empty("R4 ring drained");
    chk(mem[32'h100 >> 2] == 32'h0000_0004, "R7 flags written back",
        mem[32'h100 >> 2], 32'h0000_0004);
    chk(mem[(32'h100 >> 2) + 2] == 32'h0001_0064, "R7 status upper cleared",
        mem[(32'h100 >> 2) + 2], 32'h0001_0064);
    chk(mem[(32'h140 >> 2) + 2] == 32'h0001_003B, "R7 padded keeps length",
        mem[(32'h140 >> 2) + 2], 32'h0001_003B);
    chk(mem[32'h1C0 >> 2] == 32'h0, "R4 no write on unowned",
        mem[32'h1C0 >> 2], 32'h0);
    chk(cur_desc == 32'h1C0, "R4 pointer stays", cur_desc, 32'h1C0);
    chk(cur_buf == 32'h280, "R6 current buffer", cur_buf, 32'h280);

    // R9: buffer read error still returns the descriptor and continues
    put_desc(32'h1C0, 32'h8000_0004, 32'h390, 32'h0000_0028, 32'h100);
    push(K_SEND, 32'h390, 40); push(K_BERR, '0, 0); push(K_UNAV, '0, 0);
    demand();
    wait_idle();
    sb_empty("R9 error sequence");
    chk(mem[32'h1C0 >> 2] == 32'h0000_0004, "R9 owner returned",
        mem[32'h1C0 >> 2], 32'h0000_0004);
    chk(mem[(32'h1C0 >> 2) + 2] == 32'h0000_0028, "R9 complete bit clear",
        mem[(32'h1C0 >> 2) + 2], 32'h0000_0028);
    chk(cur_desc == 32'h100 && cur_buf == 32'h390, "R7 pointer advanced",
        cur_desc, 32'h100);

    // R10: disabling sets the sticky flag until cleared
    tx_en = 1'b0;
    @(negedge clk);
    chk(tx_halted, "R10 halted set", {31'b0, tx_halted}, 32'h1);
    repeat (3) @(negedge clk);
    chk(tx_halted, "R10 halted sticky", {31'b0, tx_halted}, 32'h1);
    halt_clr = 1'b1;
    @(negedge clk);
    halt_clr = 1'b0;
    chk(!tx_halted, "R10 halted cleared", {31'b0, tx_halted}, 32'h0);

    // R5: descriptor read error halts without a send
    list_base = 32'h3A2;
    tx_en = 1'b1;
    @(negedge clk);
    push(K_BERR, '0, 0);
    demand();
    wait_idle();
    sb_empty("R5 descriptor read error");
    chk(cur_desc == 32'h3A0, "R5 pointer kept", cur_desc, 32'h3A0);

    // R10: disable during a pending send aborts without write-back
    tx_en = 1'b0;
    @(negedge clk);
    list_base = 32'h000;
    tx_en = 1'b1;
    put_desc(32'h000, 32'h8000_0004, 32'h2C0, 32'h0000_001E, 32'h000);
    @(negedge clk);
    push(K_SEND, 32'h2C0, 30);
    demand();
    do @(negedge clk); while (!snd_start);
    tx_en = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req, "R10 abort idles", {30'b0, busy, mem_req}, 32'h0);
    chk(tx_halted, "R10 abort halted", {31'b0, tx_halted}, 32'h1);
    repeat (10) @(negedge clk);
    sb_empty("R10 no completion after abort");
    chk(mem[0] == 32'h8000_0004, "R10 no write-back", mem[0], 32'h8000_0004);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule